// File: doc/BRIEF.md
# Interval Countdown Timer

A countdown timer that sits on a simple single-cycle register port. Software loads a 32-bit period as two 16-bit halves, then starts the timer by writing a start strobe to the control register. While it runs, the live count drops by two on every clock and saturates at zero. When the count reaches zero it reloads from the period and raises a sticky timeout flag. An interrupt output is high while that flag and an interrupt-enable bit are both set.

In continuous mode the timer keeps reloading and counting. In one-shot mode it stops itself on the first reload, so the count rests at the period value. Writing either period half reloads the live count at once. Reading either snapshot register latches the whole live count and returns the requested half.

The port takes a word index, which is the byte offset divided by four. Reads return data one clock after the request.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset every readable register reads 0, `irq` is 0 and the live count is 0.
- R2: Word indices 0..5 select status, control, period low, period high, snapshot low and snapshot high. A read of index 6 or above returns 0, and a write there changes nothing.
- R3: Status has two implemented bits: bit 0 is the timeout flag and bit 1 is the run flag. Control stores bit 0 (interrupt enable) and bit 1 (continuous). Bit 2 (start) and bit 3 (stop) are strobes that read back as 0. All other bits read 0, and a bus write cannot set the run flag.
- R4: A write to index 2 replaces period bits 15:0, and a write to index 3 replaces bits 31:16. In the same clock the live count loads the full new period, and this load takes priority over counting.
- R5: A read of index 2 or index 3 returns bits 15:0 or bits 31:16 of the live count.
- R6: A start strobe sets the run flag and a stop strobe clears it. When both are written together, stop wins. The count holds while the run flag is 0.
- R7: While running, a count above 2 drops by 2 each clock. A count of 2 or less counts as reaching zero: in the same clock the counter reloads the period and sets the timeout flag, so a period P times out after ceil(P/2) running clocks.
- R8: With continuous = 1 the timer keeps running after a reload. With continuous = 0 the reload also clears the run flag, and the count stays at the period.
- R9: `irq` is 1 exactly when the interrupt enable and the timeout flag are both 1.
- R10: Any write to status clears the timeout flag. If a timeout happens in the same clock, the flag stays set.
- R11: A read of index 4 or 5 captures the live count of that clock and returns bits 15:0 or bits 31:16 of it.
- R12: `rdata` changes only on the clock edge that samples `rd_en`, and it then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| addr | input | IDX_W | Register word index |
| wdata | input | HALF_W | Write data (all implemented fields fit in 16 bits) |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request |

## Verification
The register file is tried with values that have bits set outside the implemented fields, with out-of-range indices, and with period halves written one at a time. Together these separate masking errors, decode aliasing and which half each write replaces. Counting is tried with an even period in continuous mode and an odd period in one-shot mode. The odd period drives the count through 1 so the saturation path is used, and the two runs show whether the reload keeps or drops the run flag. A zero period makes a timeout fire on every clock, which shows whether a status write or a coincident timeout wins. A period of 0x20000 shows the borrow across the two halves in snapshot reads, and it is also used to reload the counter in the middle of a run.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int NUM_REGS = 6;

  // word indices; the order is part of the software contract
  localparam int IDX_STATUS  = 0;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_PER_LO  = 2;
  localparam int IDX_PER_HI  = 3;
  localparam int IDX_SNAP_LO = 4;
  localparam int IDX_SNAP_HI = 5;

  // control bits
  localparam int CTL_IEN   = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;
  localparam int CTL_W     = 4;

  // status bits
  localparam int ST_TO  = 0;
  localparam int ST_RUN = 1;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode import itmr_pkg::*; #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]    addr,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  // one-hot selects; indices past the map select nothing
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_hit[i] = wr_en && (addr == IDX_W'(i));
    assign rd_hit[i] = rd_en && (addr == IDX_W'(i));
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int HALF_W = 16,
  parameter int STEP   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                run,
  output logic [2*HALF_W-1:0] count,
  output logic                tick
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] period_q, count_q, period_nxt;
  logic             load, at_end;

  assign load   = ld_lo | ld_hi;
  assign at_end = (count_q <= STEP_V);
  assign tick   = run && !load && at_end;

  always_comb begin
    period_nxt = period_q;
    if (ld_lo) period_nxt[HALF_W-1:0]     = wdata;
    if (ld_hi) period_nxt[CNT_W-1:HALF_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      period_q <= period_nxt;
      count_q  <= period_nxt;
    end else if (run) begin
      count_q <= at_end ? period_q : (count_q - STEP_V);
    end
  end

  assign count = count_q;
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl import itmr_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_status,
  input  logic             wr_ctrl,
  input  logic [CTL_W-1:0] ctl_bits,
  input  logic             tick,
  output logic             run_q,
  output logic             to_q,
  output logic             ien_q,
  output logic             cont_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      ien_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      // a timeout in the same cycle beats a clearing write
      if (tick)           to_q <= 1'b1;
      else if (wr_status) to_q <= 1'b0;

      if (wr_ctrl) begin
        ien_q  <= ctl_bits[CTL_IEN];
        cont_q <= ctl_bits[CTL_CONT];
      end

      if (wr_ctrl && ctl_bits[CTL_STOP])       run_q <= 1'b0;
      else if (wr_ctrl && ctl_bits[CTL_START]) run_q <= 1'b1;
      else if (tick && !cont_q)                run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/itmr_readback.sv
module itmr_readback import itmr_pkg::*; #(
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [NUM_REGS-1:0] rd_hit,
  input  logic [2*HALF_W-1:0] count,
  input  logic                to_q,
  input  logic                run_q,
  input  logic                ien_q,
  input  logic                cont_q,
  output logic [DATA_W-1:0]   rdata
);
  localparam int CNT_W = 2 * HALF_W;

  logic [DATA_W-1:0] plain_q, plain_nxt;
  logic [CNT_W-1:0]  snap_q;
  logic              sel_lo_q, sel_hi_q;

  always_comb begin
    plain_nxt = '0;
    if (rd_hit[IDX_STATUS]) begin
      plain_nxt[ST_TO]  = to_q;
      plain_nxt[ST_RUN] = run_q;
    end
    if (rd_hit[IDX_CTRL]) begin
      plain_nxt[CTL_IEN]  = ien_q;
      plain_nxt[CTL_CONT] = cont_q;
    end
    if (rd_hit[IDX_PER_LO]) plain_nxt[HALF_W-1:0] = count[HALF_W-1:0];
    if (rd_hit[IDX_PER_HI]) plain_nxt[HALF_W-1:0] = count[CNT_W-1:HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_q  <= '0;
      snap_q   <= '0;
      sel_lo_q <= 1'b0;
      sel_hi_q <= 1'b0;
    end else if (rd_en) begin
      plain_q  <= plain_nxt;
      sel_lo_q <= rd_hit[IDX_SNAP_LO];
      sel_hi_q <= rd_hit[IDX_SNAP_HI];
      if (rd_hit[IDX_SNAP_LO] || rd_hit[IDX_SNAP_HI]) snap_q <= count;
    end
  end

  always_comb begin
    rdata = plain_q;
    if (sel_lo_q)      rdata = {{(DATA_W-HALF_W){1'b0}}, snap_q[HALF_W-1:0]};
    else if (sel_hi_q) rdata = {{(DATA_W-HALF_W){1'b0}}, snap_q[CNT_W-1:HALF_W]};
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer import itmr_pkg::*; #(
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * HALF_W;

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  logic [CNT_W-1:0]    cnt_q;
  logic                tick, run_q, to_q, ien_q, cont_q;

  itmr_decode #(.IDX_W(IDX_W)) u_dec (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  itmr_counter #(.HALF_W(HALF_W), .STEP(STEP)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (wr_hit[IDX_PER_LO]),
    .ld_hi (wr_hit[IDX_PER_HI]),
    .wdata (wdata),
    .run   (run_q),
    .count (cnt_q),
    .tick  (tick)
  );

  itmr_ctrl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_status (wr_hit[IDX_STATUS]),
    .wr_ctrl   (wr_hit[IDX_CTRL]),
    .ctl_bits  (wdata[CTL_W-1:0]),
    .tick      (tick),
    .run_q     (run_q),
    .to_q      (to_q),
    .ien_q     (ien_q),
    .cont_q    (cont_q)
  );

  itmr_readback #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_hit (rd_hit),
    .count  (cnt_q),
    .to_q   (to_q),
    .run_q  (run_q),
    .ien_q  (ien_q),
    .cont_q (cont_q),
    .rdata  (rdata)
  );

  // both inputs are flops, so the output has no combinational path from the bus
  assign irq = ien_q & to_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int IDX_W  = 4,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32,
  parameter int STEP   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [IDX_W-1:0]    addr,
  input logic [HALF_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq,
  input logic [2*HALF_W-1:0] count,
  input logic                run,
  input logic                to_q,
  input logic                ien,
  input logic                cont
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic wr_per, wr_stat, wr_ctl, ends;
  assign wr_per  = wr_en && (addr == IDX_W'(2) || addr == IDX_W'(3));
  assign wr_stat = wr_en && (addr == IDX_W'(0));
  assign wr_ctl  = wr_en && (addr == IDX_W'(1));
  assign ends    = run && !wr_per && (count <= STEP_V);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rdata == '0 && !irq && count == '0));

  a_r2_oob_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= IDX_W'(6)) |=> (rdata == '0));

  a_r4_low_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == IDX_W'(2)) |=> (count[HALF_W-1:0] == $past(wdata)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_per) |=> $stable(count));

  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_per && count > STEP_V) |=> (count == $past(count) - STEP_V));

  a_r7_timeout: assert property (@(posedge clk) disable iff (rst)
    ends |=> to_q);

  a_r8_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
    (ends && !cont && !wr_ctl) |=> !run);

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (ien && to_q && !wr_stat && !wr_ctl) |=> irq);

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !ends) |=> !to_q);
endmodule

bind interval_timer itmr_checker #(
  .IDX_W(IDX_W), .HALF_W(HALF_W), .DATA_W(DATA_W), .STEP(STEP)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq),
  .count (cnt_q),
  .run   (run_q),
  .to_q  (to_q),
  .ien   (ien_q),
  .cont  (cont_q)
);

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam int IDX_W = 4, HALF_W = 16, DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [IDX_W-1:0]  addr = '0;
  logic [HALF_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  interval_timer #(.IDX_W(IDX_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  idx;
    logic [15:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd2,  16'hABCD, 32'h0,      4'd4},  // R4 low half
    '{1'b0, 4'd2,  16'h0,    32'hABCD,   4'd4},  // R4
    '{1'b0, 4'd3,  16'h0,    32'h0,      4'd4},  // R4 high untouched
    '{1'b1, 4'd3,  16'h0007, 32'h0,      4'd4},
    '{1'b0, 4'd3,  16'h0,    32'h7,      4'd5},  // R5
    '{1'b0, 4'd2,  16'h0,    32'hABCD,   4'd5},  // R5
    '{1'b0, 4'd4,  16'h0,    32'hABCD,   4'd11}, // R11
    '{1'b0, 4'd5,  16'h0,    32'h7,      4'd11}, // R11
    '{1'b1, 4'd1,  16'hFFF3, 32'h0,      4'd3},
    '{1'b0, 4'd1,  16'h0,    32'h3,      4'd3},  // R3 mask
    '{1'b1, 4'd0,  16'hFFFF, 32'h0,      4'd3},
    '{1'b0, 4'd0,  16'h0,    32'h0,      4'd3},  // R3 run not writable
    '{1'b1, 4'd6,  16'h5555, 32'h0,      4'd2},
    '{1'b0, 4'd6,  16'h0,    32'h0,      4'd2},  // R2
    '{1'b0, 4'd15, 16'h0,    32'h0,      4'd2},  // R2
    '{1'b0, 4'd2,  16'h0,    32'hABCD,   4'd2},  // R2 write ignored
    '{1'b1, 4'd1,  16'h0000, 32'h0,      4'd3},
    '{1'b0, 4'd1,  16'h0,    32'h0,      4'd3}   // R3
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [IDX_W-1:0] a, input logic [HALF_W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [IDX_W-1:0] a, output logic [DATA_W-1:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(1, {31'b0, irq}, 32'h0, "irq after reset");
    for (int i = 0; i < 6; i++) begin
      bus_rd(IDX_W'(i), d);
      check(1, d, 32'h0, "register after reset");
    end

    // table walk (timer idle)
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) bus_wr(VECS[v].idx, VECS[v].data);
      else begin
        bus_rd(VECS[v].idx, d);
        check(int'(VECS[v].req), d, VECS[v].exp, "table vector");
      end
    end

    // R12: rdata holds between reads
    bus_rd(4'd2, d);
    repeat (3) @(negedge clk);
    check(12, rdata, 32'h0000_ABCD, "rdata hold");

    // R7/R8 continuous run, period 10
    bus_wr(4'd3, 16'h0);
    bus_wr(4'd2, 16'd10);
    bus_wr(4'd1, 16'h6);                  // cont + start
    begin
      int exp_seq [7] = '{10, 8, 6, 4, 2, 10, 8};
      for (int k = 0; k < 7; k++) begin
        bus_rd(4'd2, d);
        check(7, d, 32'(exp_seq[k]), "continuous count sequence");
      end
    end
    bus_rd(4'd0, d);
    check(8, d, 32'h3, "continuous keeps running with timeout");
    check(9, {31'b0, irq}, 32'h0, "irq masked");
    bus_wr(4'd1, 16'hB);                  // ien + cont + stop
    check(9, {31'b0, irq}, 32'h1, "irq asserted");
    bus_rd(4'd2, d);
    repeat (3) @(negedge clk);
    bus_rd(4'd2, d2);
    check(6, d2, d, "count frozen when stopped");
    bus_wr(4'd0, 16'h0);
    check(10, {31'b0, irq}, 32'h0, "irq after status write");
    bus_rd(4'd0, d);
    check(10, d, 32'h0, "timeout cleared");

    // R6: stop dominates start
    bus_wr(4'd1, 16'hC);
    bus_rd(4'd0, d);
    check(6, d, 32'h0, "stop wins over start");

    // R8 one-shot, odd period 5 (also R7 saturation through 1)
    bus_wr(4'd2, 16'd5);
    bus_wr(4'd1, 16'h5);                  // ien + start, one-shot
    begin
      int exp_seq [6] = '{5, 3, 1, 5, 5, 5};
      for (int k = 0; k < 6; k++) begin
        bus_rd(4'd2, d);
        check(8, d, 32'(exp_seq[k]), "one-shot count sequence");
      end
    end
    bus_rd(4'd0, d);
    check(8, d, 32'h1, "one-shot halted with timeout");
    check(9, {31'b0, irq}, 32'h1, "irq one-shot");
    bus_wr(4'd0, 16'h0);

    // R11 snapshot with borrow, R4 reload while running
    bus_wr(4'd3, 16'h2);
    bus_wr(4'd2, 16'h0);
    bus_wr(4'd1, 16'h6);
    bus_rd(4'd4, d);
    check(11, d, 32'h0, "snapshot low live");
    bus_rd(4'd5, d);
    check(11, d, 32'h1, "snapshot high after borrow");
    bus_wr(4'd2, 16'h6);
    bus_rd(4'd2, d);
    check(4, d, 32'h6, "reload while running low");
    bus_rd(4'd3, d);
    check(4, d, 32'h2, "reload while running high");
    bus_wr(4'd1, 16'h8);

    // R10: timeout coincident with status write, period 0
    bus_wr(4'd3, 16'h0);
    bus_wr(4'd2, 16'h0);
    bus_wr(4'd1, 16'h6);
    bus_wr(4'd0, 16'h0);
    bus_rd(4'd0, d);
    check(10, d, 32'h3, "timeout wins over clear");
    bus_wr(4'd1, 16'h8);
    bus_wr(4'd0, 16'h0);
    bus_rd(4'd0, d);
    check(10, d, 32'h0, "cleared when idle");

    done = 1;
    summary();
  end
endmodule